// File: doc/BRIEF.md
# Gated PWM Waveform Combiner

This block merges two compare-derived square waves with one shared pulse train to drive two switching outputs. In chopper mode each output carries the pulse train only while its own compare wave is high, so one external pulse generator can chop two PWM phases at once. A gate request, built as the OR of the enabled compare waves, tells that pulse generator when to run and when to stop.

A pass-through mode copies each compare wave straight to its output and keeps the gate request low. The other mode codes are treated as idle: the outputs and the gate stay low. The configuration inputs are captured in a register every clock. The outputs and the gate are taken from a second register stage, so none of them can glitch.

Top module: `gated_pwm_combiner`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wave_o` and `gate_o` become 0 and the captured configuration becomes pass-through. So the first output update after reset is released uses pass-through, whatever the mode inputs are.
- R2: With mode code 3'b000 (pass-through), `wave_o[i]` equals `cmp_i[i]` and `gate_o` is 0.
- R3: With mode code 3'b001 (chopper) and `pulse_en_i[i]` = 1, `wave_o[i]` equals `cmp_i[i]` AND `pulse_i`.
- R4: In chopper mode with `pulse_en_i[i]` = 0, `wave_o[i]` equals `cmp_i[i]` with no chopping.
- R5: In chopper mode, `gate_o` is the OR, over i, of `gate_en_i[i]` AND `cmp_i[i]`. Bit i of `gate_en_i` belongs to channel i, so 2'b11 gives the OR of both compare waves.
- R6: In chopper mode, when every compare wave is low, the gate and both outputs are low whatever the pulse train does.
- R7: Any mode code other than 3'b000 and 3'b001 drives `wave_o` and `gate_o` to 0.
- R8: `wave_o` and `gate_o` follow a change on `cmp_i` or `pulse_i` one clock edge later. A configuration change reaches them two edges later.
- R9: In chopper mode with `gate_en_i` = 2'b00, `gate_o` stays 0 even while the compare waves are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Mode code: 000 pass-through, 001 chopper, any other value idle |
| gate_en_i | input | NCH | Per-channel enable of the compare wave into the gate request |
| pulse_en_i | input | NCH | Per-channel enable of the pulse train onto the output |
| cmp_i | input | NCH | Compare-derived square waves |
| pulse_i | input | 1 | Shared pulse train from the external generator |
| gate_o | output | 1 | Gate request that starts and stops the pulse generator |
| wave_o | output | NCH | Combined output waves |

## Verification
The bench checks the per-channel masks with one bit set and the other clear. A design that swaps the bit order, or applies a mask to both channels, chops the wrong phase or gates on the wrong wave. It runs chopper mode with both compare waves low and the pulse train high. A design that lets the pulse through on its own shows activity there. Reserved mode codes are checked to be silent, which catches a decoder that tests only the low mode bit. The first cycle after reset is checked to use pass-through. A direct check on latency catches a missing or an extra register stage.

// File: rtl/wfc_pkg.sv
// Shared definitions for the gated PWM waveform combiner.
// Assumes: mode codes are three bits wide; codes other than the two listed are idle.
package wfc_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_PASS = 3'b000,
        MODE_CHOP = 3'b001
    } wfc_mode_e;
endpackage

// File: rtl/wfc_cfg_reg.sv
// Configuration capture register.
// What it does: takes the mode code and the two per-channel masks each clock.
// Assumes: reset is synchronous and active low; the reset value is pass-through with all masks clear.
module wfc_cfg_reg
    import wfc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [NCH-1:0]    gate_en_i,
    input  logic [NCH-1:0]    pulse_en_i,
    output logic [MODE_W-1:0] mode_q,
    output logic [NCH-1:0]    gate_en_q,
    output logic [NCH-1:0]    pulse_en_q
);
    // Purpose: load the configuration, or force the pass-through default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_PASS;
            gate_en_q  <= '0;
            pulse_en_q <= '0;
        end else begin
            mode_q     <= mode_i;
            gate_en_q  <= gate_en_i;
            pulse_en_q <= pulse_en_i;
        end
    end

    // R1: after a reset cycle the captured mode is pass-through.
    a_r1_cfg_reset_pass: assert property (@(posedge clk)
        !rst_n |=> (mode_q == MODE_PASS));
endmodule

// File: rtl/wfc_chan.sv
// One output channel of the combiner.
// What it does: passes the compare wave through, chops it with the pulse train,
// or holds the output low, depending on the decoded mode. The result is registered.
// Assumes: at most one of chop_en and pass_en is set; both clear means idle.
module wfc_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic chop_en,
    input  logic pass_en,
    input  logic apply_i,
    input  logic cmp_i,
    input  logic pulse_i,
    output logic wave_q
);
    logic wave_d;

    // Purpose: choose the next output level from the mode, the mask and the inputs.
    always_comb begin
        if (pass_en) begin
            wave_d = cmp_i;
        end else if (chop_en) begin
            wave_d = apply_i ? (cmp_i & pulse_i) : cmp_i;
        end else begin
            wave_d = 1'b0;
        end
    end

    // Purpose: register the output so that it cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else begin
            wave_q <= wave_d;
        end
    end

    // R6: an output can be high only if its compare wave was high one cycle before.
    a_r6_wave_needs_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        wave_q |-> $past(cmp_i));

    // R3: a chopped channel is low after a pulse gap.
    a_r3_chop_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_en && apply_i && !pulse_i) |=> !wave_q);

    // R7: an idle mode leaves the output low.
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!chop_en && !pass_en) |=> !wave_q);

    // R4: an unchopped channel in chopper mode follows its compare wave.
    a_r4_unchopped_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_en && !apply_i) |=> (wave_q == $past(cmp_i)));
endmodule

// File: rtl/wfc_gate.sv
// Gate request generator.
// What it does: ORs the enabled compare waves into one registered request for the
// pulse generator. The request is active only in chopper mode.
// Assumes: bit i of gate_en_i belongs to compare wave i.
module wfc_gate #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           chop_en,
    input  logic [NCH-1:0] gate_en_i,
    input  logic [NCH-1:0] cmp_i,
    output logic           gate_q
);
    logic [NCH-1:0] src;
    logic           gate_d;

    // Purpose: mask each compare wave with its enable bit.
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_src
            assign src[g] = gate_en_i[g] & cmp_i[g];
        end
    endgenerate

    // Purpose: form the request, which is active only in chopper mode.
    always_comb begin
        gate_d = chop_en & (|src);
    end

    // Purpose: register the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    // R2: outside chopper mode the gate is low one cycle later.
    a_r2_gate_low_nochop: assert property (@(posedge clk) disable iff (!rst_n)
        !chop_en |=> !gate_q);

    // R5: a high gate traces back to an enabled, high compare wave.
    a_r5_gate_source: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> $past(|(gate_en_i & cmp_i)));

    // R9: with both enables clear the gate stays low.
    a_r9_no_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_i == '0) |=> !gate_q);
endmodule

// File: rtl/gated_pwm_combiner.sv
// Gated PWM waveform combiner, top level.
// What it does: registers the configuration, decodes the mode, and drives NCH
// channel units plus one gate unit that share the pulse train.
// Assumes: the inputs are synchronous to clk; reset is synchronous and active low.
module gated_pwm_combiner
    import wfc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [NCH-1:0]    gate_en_i,
    input  logic [NCH-1:0]    pulse_en_i,
    input  logic [NCH-1:0]    cmp_i,
    input  logic              pulse_i,
    output logic              gate_o,
    output logic [NCH-1:0]    wave_o
);
    logic [MODE_W-1:0] mode_q;
    logic [NCH-1:0]    gate_en_q;
    logic [NCH-1:0]    pulse_en_q;
    logic              chop_en;
    logic              pass_en;

    wfc_cfg_reg #(.NCH(NCH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .gate_en_i  (gate_en_i),
        .pulse_en_i (pulse_en_i),
        .mode_q     (mode_q),
        .gate_en_q  (gate_en_q),
        .pulse_en_q (pulse_en_q)
    );

    // Purpose: decode the captured mode code into one-hot selects.
    always_comb begin
        chop_en = (mode_q == MODE_CHOP);
        pass_en = (mode_q == MODE_PASS);
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            wfc_chan u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .chop_en (chop_en),
                .pass_en (pass_en),
                .apply_i (pulse_en_q[c]),
                .cmp_i   (cmp_i[c]),
                .pulse_i (pulse_i),
                .wave_q  (wave_o[c])
            );
        end
    endgenerate

    wfc_gate #(.NCH(NCH)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .chop_en   (chop_en),
        .gate_en_i (gate_en_q),
        .cmp_i     (cmp_i),
        .gate_q    (gate_o)
    );

    // R1: a reset cycle leaves the outputs and the gate low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!gate_o && wave_o == '0));

    // R2: in pass-through mode the outputs copy the compare waves one cycle later.
    a_r2_pass_copy: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en |=> (wave_o == $past(cmp_i)));
endmodule

// File: tb/gated_pwm_combiner_tb.sv
// Bench for the gated PWM waveform combiner: a vector table, then directed checks.
module gated_pwm_combiner_tb;
    localparam int NCH = 2;
    localparam int NV  = 16;
    // Vector fields: req, mode, gate_en, pulse_en, cmp, pulse, exp_gate, exp_wave
    localparam logic [16:0] VEC [NV] = '{
        {4'd2, 3'b000, 2'b11, 2'b11, 2'b01, 1'b0, 1'b0, 2'b01},
        {4'd2, 3'b000, 2'b11, 2'b11, 2'b10, 1'b1, 1'b0, 2'b10},
        {4'd2, 3'b000, 2'b11, 2'b11, 2'b11, 1'b0, 1'b0, 2'b11},
        {4'd3, 3'b001, 2'b11, 2'b11, 2'b11, 1'b1, 1'b1, 2'b11},
        {4'd3, 3'b001, 2'b11, 2'b11, 2'b11, 1'b0, 1'b1, 2'b00},
        {4'd3, 3'b001, 2'b11, 2'b11, 2'b01, 1'b1, 1'b1, 2'b01},
        {4'd5, 3'b001, 2'b11, 2'b11, 2'b10, 1'b1, 1'b1, 2'b10},
        {4'd6, 3'b001, 2'b11, 2'b11, 2'b00, 1'b1, 1'b0, 2'b00},
        {4'd4, 3'b001, 2'b11, 2'b01, 2'b11, 1'b0, 1'b1, 2'b10},
        {4'd4, 3'b001, 2'b11, 2'b10, 2'b11, 1'b0, 1'b1, 2'b01},
        {4'd5, 3'b001, 2'b01, 2'b11, 2'b10, 1'b1, 1'b0, 2'b10},
        {4'd5, 3'b001, 2'b10, 2'b11, 2'b10, 1'b1, 1'b1, 2'b10},
        {4'd9, 3'b001, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0, 2'b11},
        {4'd7, 3'b010, 2'b11, 2'b11, 2'b11, 1'b1, 1'b0, 2'b00},
        {4'd7, 3'b111, 2'b11, 2'b11, 2'b11, 1'b1, 1'b0, 2'b00},
        {4'd4, 3'b001, 2'b11, 2'b00, 2'b11, 1'b0, 1'b1, 2'b11}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic [2:0]     mode_i;
    logic [NCH-1:0] gate_en_i;
    logic [NCH-1:0] pulse_en_i;
    logic [NCH-1:0] cmp_i;
    logic           pulse_i;
    logic           gate_o;
    logic [NCH-1:0] wave_o;
    int             total = 0;
    int             bad = 0;

    always #5 clk = ~clk;

    gated_pwm_combiner #(.NCH(NCH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .gate_en_i  (gate_en_i),
        .pulse_en_i (pulse_en_i),
        .cmp_i      (cmp_i),
        .pulse_i    (pulse_i),
        .gate_o     (gate_o),
        .wave_o     (wave_o)
    );

    task automatic check(input string req, input logic eg, input logic [1:0] ew);
        total++;
        if (gate_o !== eg || wave_o !== ew) begin
            bad++;
            $display("FAIL %s: gate=%b wave=%b expected gate=%b wave=%b",
                     req, gate_o, wave_o, eg, ew);
        end
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: run hung, gate=%b wave=%b expected completion", gate_o, wave_o);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        mode_i = 3'b001; gate_en_i = 2'b11; pulse_en_i = 2'b11;
        cmp_i = 2'b11; pulse_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset quiet", 1'b0, 2'b00);

        // R1/R8: first edge after release uses the reset pass-through config.
        pulse_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pass default after reset", 1'b0, 2'b11);
        @(negedge clk);
        check("R8 config after two edges", 1'b1, 2'b00);

        // Table walk: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            {mode_i, gate_en_i, pulse_en_i, cmp_i, pulse_i} = VEC[i][12:3];
            repeat (2) @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][16:13], i), VEC[i][2], VEC[i][1:0]);
        end

        // R8: a data change shows up after exactly one edge, not before.
        mode_i = 3'b001; gate_en_i = 2'b11; pulse_en_i = 2'b11;
        cmp_i = 2'b11; pulse_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 settle", 1'b1, 2'b11);
        pulse_i = 1'b0;
        #1;
        check("R8 no change before edge", 1'b1, 2'b11);
        @(negedge clk);
        check("R8 one edge latency", 1'b1, 2'b00);

        // R6: pulse train toggling with no compare activity stays silent.
        cmp_i = 2'b00;
        for (int k = 0; k < 6; k++) begin
            pulse_i = k[0];
            @(negedge clk);
            if (k > 0) check("R6 no activity without compare", 1'b0, 2'b00);
        end

        // R3: chopped channel tracks a toggling pulse train cycle by cycle.
        cmp_i = 2'b01;
        for (int k = 0; k < 4; k++) begin
            pulse_i = k[0];
            @(negedge clk);
            check("R3 chop follows pulse", 1'b1, {1'b0, k[0]});
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule